// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable behavioural model of a small single-port synchronous SRAM. Reads and writes share one data bus. The write data is deliberately taken late so that its delay matches the read data delay. A controller can therefore alternate reads and writes on every clock, with no idle cycle on the bus. A static mode pin selects one of two latencies. In pipelined mode, read data comes out of an output register. In flow-through mode, read data is driven straight from the array one cycle earlier, and write data is taken one cycle earlier to match.

A command is captured at an enabled clock edge. The block keeps the command in a short pipeline until its data phase arrives. At the data edge, a write merges the bus data into the selected byte lanes. In pipelined mode, a read issued right after a write to the same word would otherwise fetch the array before that write lands. The output register handles this case: it takes the incoming bytes of the pending write in place of the stale array bytes. The clock enable freezes the whole block. The mode pin is changed only while no command is in flight. Advance/load high (burst continuation) is treated as no operation.

Top module: `lockstep_sram`

## Requirements
- R1: While `clkEnN` is high at a rising edge, that edge has no effect. The command pipeline, the memory array, `dOut` and `dOutEn` all keep their values. A command in flight resumes at the next enabled edge.
- R2: A command is accepted only when `ce1N` is low, `ce2` is high and `ce3N` is low at the edge. If any one of them is inactive, no read or write takes place.
- R3: A command needs `advLdN` low. With `advLdN` high, nothing is read or written. When the command is accepted, `wrEnN` high selects a read and `wrEnN` low selects a write.
- R4: Pipelined mode (`flowMode` = 0): for a read accepted at enabled edge k, `dOutEn` is high and `dOut` holds the word from the edge after enabled edge k+1 until enabled edge k+2. `dOutEn` is low in the cycle after edge k.
- R5: Pipelined mode: for a write accepted at enabled edge k, `dIn` is sampled at enabled edge k+2.
- R6: Flow-through mode (`flowMode` = 1): for a read accepted at enabled edge k, `dOutEn` is high and `dOut` holds the word from just after edge k until enabled edge k+1.
- R7: Flow-through mode: for a write accepted at enabled edge k, `dIn` is sampled at enabled edge k+1.
- R8: `byteWrN[i]` low writes bits [8i+7:8i]. The bytes whose enable is high keep their old value. A write with all four enables high leaves the word unchanged.
- R9: In both modes, a read, a write and a read can be issued on three consecutive enabled edges. The bus then carries read data, then write data, then read data in consecutive cycles, and `dOutEn` is low only in the write data cycle.
- R10: In pipelined mode, a read issued one edge after a write to the same address returns the newly written bytes in the enabled lanes and the old bytes elsewhere.
- R11: After reset, `dOutEn` is low and every word reads as zero.
- R12: `dOutEn` is high only in the cycles R4 and R6 name. It is low in write data cycles and after rejected commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| advLdN | input | 1 | Low loads a new address and command |
| wrEnN | input | 1 | High = read, low = write |
| byteWrN | input | 4 | Byte lane write enables, active low |
| addr | input | ADDR_W | Word address |
| dIn | input | DATA_W | Write data from the bus |
| flowMode | input | 1 | 1 = flow-through, 0 = pipelined |
| dOut | output | DATA_W | Read data to the bus |
| dOutEn | output | 1 | Bus drive enable, high while read data is valid |

## Verification
The bound checker watches the following on every cycle:
- The output stays frozen across a suspended edge.
- A flow-through read raises the drive enable at the next edge.
- A flow-through write or a deselected command keeps the drive enable low.
- An output-register load in pipelined mode always shows up as a driven cycle.

Only the bench scenarios can confirm the data values. These are the byte-lane merges, the no-op write, the late sampling of write data in each mode and the bytes forwarded from a pending write. The bench also checks that suspension delays a pending write's data phase without losing it.

// File: rtl/lockstep_sram_pkg.sv
package lockstep_sram_pkg;

  // Number of byte lanes; fixed by the four byte-enable pins.
  localparam int NUM_LANES = 4;

  // Command flags carried down the delay pipeline.
  typedef struct packed {
    logic                 vld;
    logic                 wr;
    logic [NUM_LANES-1:0] lanes;   // active-high byte enables
  } cmdFlags_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 adv;       // enabled clock edge
    logic                 wrCommit;  // a write reaches its data edge
    logic                 rdLoad;    // pipelined read loads the output register
    logic                 flowRd;    // flow-through read drives the bus now
    logic [NUM_LANES-1:0] wrLanes;   // lanes written at commit
    logic [NUM_LANES-1:0] fwdLanes;  // lanes taken from dIn into the read
  } strobe_t;

endpackage

// File: rtl/lockstep_sram_ctrl.sv
module lockstep_sram_ctrl
  import lockstep_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clkEnN,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 ce3N,
  input  logic                 advLdN,
  input  logic                 wrEnN,
  input  logic [NUM_LANES-1:0] byteWrN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 flowMode,
  output strobe_t              strb,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [ADDR_W-1:0]    rdAddr
);

  localparam int STAGES = 2;

  logic      advance;
  logic      selected;
  cmdFlags_t nxtCmd;
  cmdFlags_t stFlags [STAGES];
  logic [ADDR_W-1:0] stAddr [STAGES];
  cmdFlags_t wrSrc;

  assign advance  = !clkEnN;
  assign selected = !ce1N && ce2 && !ce3N && !advLdN;

  always_comb begin
    nxtCmd.vld   = selected;
    nxtCmd.wr    = !wrEnN;
    nxtCmd.lanes = ~byteWrN;
  end

  // Command delay line: stage 0 is the command just captured.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stFlags[s] <= '0;
        stAddr[s]  <= '0;
      end else if (advance) begin
        if (s == 0) begin
          stFlags[s] <= nxtCmd;
          stAddr[s]  <= addr;
        end else begin
          stFlags[s] <= stFlags[s-1];
          stAddr[s]  <= stAddr[s-1];
        end
      end
    end
  end

  // The write data edge is one stage later in pipelined mode.
  always_comb begin
    wrSrc  = flowMode ? stFlags[0] : stFlags[1];
    wrAddr = flowMode ? stAddr[0]  : stAddr[1];
    rdAddr = stAddr[0];

    strb.adv      = advance;
    strb.wrCommit = wrSrc.vld && wrSrc.wr;
    strb.wrLanes  = strb.wrCommit ? wrSrc.lanes : '0;
    strb.rdLoad   = !flowMode && stFlags[0].vld && !stFlags[0].wr;
    strb.flowRd   = flowMode && stFlags[0].vld && !stFlags[0].wr;
    strb.fwdLanes = (strb.rdLoad && strb.wrCommit && (stAddr[1] == stAddr[0]))
                    ? strb.wrLanes : '0;
  end

endmodule

// File: rtl/lockstep_sram_dp.sv
module lockstep_sram_dp
  import lockstep_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  strobe_t                       strb,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [ADDR_W-1:0]             rdAddr,
  input  logic [NUM_LANES*LANE_W-1:0]   dIn,
  input  logic                          flowMode,
  output logic [NUM_LANES*LANE_W-1:0]   dOut,
  output logic                          dOutEn
);

  localparam int DATA_W = NUM_LANES * LANE_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] outReg;
  logic              outVld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) memArr[w] <= '0;
    end else if (strb.adv && strb.wrCommit) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (strb.wrLanes[l]) memArr[wrAddr][l*LANE_W +: LANE_W] <= dIn[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdWord = memArr[rdAddr];

  // Per-lane choice between the array and the write landing this edge.
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = strb.fwdLanes[l] ? dIn[l*LANE_W +: LANE_W]
                                                         : rdWord[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outReg <= '0;
      outVld <= 1'b0;
    end else if (strb.adv) begin
      if (strb.rdLoad) outReg <= merged;
      outVld <= strb.rdLoad;
    end
  end

  assign dOut   = flowMode ? rdWord      : outReg;
  assign dOutEn = flowMode ? strb.flowRd : outVld;

endmodule

// File: rtl/lockstep_sram.sv
module lockstep_sram
  import lockstep_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clkEnN,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 ce3N,
  input  logic                 advLdN,
  input  logic                 wrEnN,
  input  logic [NUM_LANES-1:0] byteWrN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    dIn,
  input  logic                 flowMode,
  output logic [DATA_W-1:0]    dOut,
  output logic                 dOutEn
);

  strobe_t           strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  lockstep_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clkEnN(clkEnN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .advLdN(advLdN), .wrEnN(wrEnN), .byteWrN(byteWrN),
    .addr(addr), .flowMode(flowMode),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  lockstep_sram_dp #(.DEPTH(DEPTH), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dIn(dIn),
    .flowMode(flowMode), .dOut(dOut), .dOutEn(dOutEn)
  );

endmodule

// File: rtl/lockstep_sram_chk.sv
module lockstep_sram_chk
  import lockstep_sram_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clkEnN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              advLdN,
  input logic              wrEnN,
  input logic              flowMode,
  input logic [DATA_W-1:0] dOut,
  input logic              dOutEn,
  input strobe_t           strb
);

  logic chipOn;
  assign chipOn = !ce1N && ce2 && !ce3N;

  // R1
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkEnN |=> ($stable(dOutEn) && $stable(dOut)));

  // R6
  flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && flowMode && chipOn && !advLdN && wrEnN) |=> dOutEn);

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && flowMode && !chipOn) |=> !dOutEn);

  // R12
  write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && flowMode && chipOn && !advLdN && !wrEnN) |=> !dOutEn);

  // R4
  pipe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.adv && strb.rdLoad) |=> dOutEn);

endmodule

bind lockstep_sram lockstep_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clkEnN(clkEnN),
  .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
  .advLdN(advLdN), .wrEnN(wrEnN), .flowMode(flowMode),
  .dOut(dOut), .dOutEn(dOutEn), .strb(strb)
);

// File: tb/lockstep_sram_bench.sv
module lockstep_sram_bench;

  localparam int DEPTH = 256;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clkEnN = 1'b0;
  logic          ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic          advLdN = 1'b0, wrEnN = 1'b1;
  logic [3:0]    byteWrN = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dIn = '0;
  logic          flowMode = 1'b0;
  logic [DW-1:0] dOut;
  logic          dOutEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  lockstep_sram u_lockstep_sram (
    .clk(clk), .rst_n(rst_n), .clkEnN(clkEnN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .advLdN(advLdN), .wrEnN(wrEnN), .byteWrN(byteWrN),
    .addr(addr), .dIn(dIn), .flowMode(flowMode),
    .dOut(dOut), .dOutEn(dOutEn)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmdIdle;
    ce1N = 1'b1; ce2 = 1'b0; ce3N = 1'b1; advLdN = 1'b0; wrEnN = 1'b1; byteWrN = 4'hF;
  endtask

  task automatic cmdRead(logic [AW-1:0] a);
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0; advLdN = 1'b0; wrEnN = 1'b1; byteWrN = 4'hF; addr = a;
  endtask

  task automatic cmdWrite(logic [AW-1:0] a, logic [3:0] lanesN);
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0; advLdN = 1'b0; wrEnN = 1'b0; byteWrN = lanesN; addr = a;
  endtask

  function automatic logic [DW-1:0] mergeLanes(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] lanesN);
    logic [DW-1:0] r = old;
    for (int l = 0; l < 4; l++) if (!lanesN[l]) r[l*8 +: 8] = nw[l*8 +: 8];
    return r;
  endfunction

  task automatic doWrite(logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] lanesN);
    cmdWrite(a, lanesN);
    tick;
    cmdIdle;
    if (!flowMode) tick;
    dIn = d;
    tick;
    dIn = '0;
    model[a] = mergeLanes(model[a], d, lanesN);
  endtask

  task automatic doRead(logic [AW-1:0] a, string req);
    cmdRead(a);
    tick;
    cmdIdle;
    if (flowMode) begin
      chk({req, " flow drive"}, dOutEn, 1);
      chk({req, " flow data"}, dOut, model[a]);
      tick;
      chk({req, " flow release"}, dOutEn, 0);
    end else begin
      chk({req, " not early"}, dOutEn, 0);
      tick;
      chk({req, " pipe drive"}, dOutEn, 1);
      chk({req, " pipe data"}, dOut, model[a]);
      tick;
      chk({req, " pipe release"}, dOutEn, 0);
    end
  endtask

  task automatic t_reset;
    chk("R11 enable low", dOutEn, 0);
    doRead(8'd5, "R11");
    doRead(8'd255, "R11");
  endtask

  task automatic t_pipeBasic;
    flowMode = 1'b0;
    doWrite(8'd3, 32'hCAFE_0123, 4'h0);
    doRead(8'd3, "R4/R5");
    doWrite(8'd4, 32'h0BAD_F00D, 4'h0);
    doRead(8'd4, "R5");
  endtask

  task automatic t_byteMask;
    flowMode = 1'b0;
    doWrite(8'd3, 32'h77EE_9911, 4'b1011);
    doRead(8'd3, "R8 lane2");
    doWrite(8'd3, 32'h1234_5678, 4'b0110);
    doRead(8'd3, "R8 lanes0,3");
    doWrite(8'd3, 32'hFFFF_FFFF, 4'hF);
    doRead(8'd3, "R8 no-op");
  endtask

  task automatic t_flow;
    flowMode = 1'b1;
    tick;
    doWrite(8'd7, 32'hA5A5_5A5A, 4'h0);
    doRead(8'd7, "R6/R7");
    doWrite(8'd7, 32'h0000_00C3, 4'b1110);
    doRead(8'd7, "R7 lane0");
  endtask

  task automatic t_deselect;
    flowMode = 1'b1;
    for (int c = 0; c < 3; c++) begin
      cmdWrite(8'd20, 4'h0);
      if (c == 0) ce1N = 1'b1;
      if (c == 1) ce2 = 1'b0;
      if (c == 2) ce3N = 1'b1;
      tick;
      cmdIdle;
      dIn = 32'hDEAD_0000 + c;
      tick;
      dIn = '0;
    end
    doRead(8'd20, "R2 no write");
    cmdRead(8'd7);
    ce2 = 1'b0;
    tick;
    cmdIdle;
    chk("R2 deselected read", dOutEn, 0);
    cmdWrite(8'd21, 4'h0);
    advLdN = 1'b1;
    tick;
    cmdIdle;
    dIn = 32'h5555_AAAA;
    tick;
    dIn = '0;
    doRead(8'd21, "R3 no write");
    cmdRead(8'd7);
    advLdN = 1'b1;
    tick;
    cmdIdle;
    chk("R3 advance high read", dOutEn, 0);
  endtask

  task automatic t_suspend;
    flowMode = 1'b0;
    tick;
    cmdRead(8'd3);
    tick;
    cmdIdle;
    clkEnN = 1'b1;
    tick;
    tick;
    chk("R1 held before data", dOutEn, 0);
    clkEnN = 1'b0;
    tick;
    chk("R1 resumed drive", dOutEn, 1);
    chk("R1 resumed data", dOut, model[3]);
    clkEnN = 1'b1;
    tick;
    tick;
    chk("R1 held drive", dOutEn, 1);
    chk("R1 held data", dOut, model[3]);
    clkEnN = 1'b0;
    tick;
    chk("R1 release", dOutEn, 0);
    cmdWrite(8'd9, 4'h0);
    tick;
    cmdIdle;
    clkEnN = 1'b1;
    dIn = 32'hBAD0_BAD0;
    tick;
    tick;
    clkEnN = 1'b0;
    tick;
    dIn = 32'h600D_D474;
    tick;
    dIn = '0;
    model[9] = 32'h600D_D474;
    doRead(8'd9, "R1 suspended write");
  endtask

  task automatic t_backToBack;
    flowMode = 1'b0;
    tick;
    doWrite(8'd40, 32'h1122_3344, 4'h0);
    doWrite(8'd41, 32'hAABB_CCDD, 4'h0);
    cmdRead(8'd40);
    tick;
    cmdWrite(8'd41, 4'b1100);
    tick;
    chk("R9 pipe first read drive", dOutEn, 1);
    chk("R9 pipe first read data", dOut, model[40]);
    cmdRead(8'd41);
    tick;
    chk("R9 pipe write slot", dOutEn, 0);
    cmdIdle;
    dIn = 32'h5566_7788;
    tick;
    dIn = '0;
    model[41] = mergeLanes(model[41], 32'h5566_7788, 4'b1100);
    chk("R10 forward drive", dOutEn, 1);
    chk("R10 forwarded merge", dOut, 32'hAABB_7788);
    tick;
    chk("R9 pipe release", dOutEn, 0);
    doRead(8'd41, "R10 committed");

    flowMode = 1'b1;
    tick;
    cmdRead(8'd40);
    tick;
    chk("R9 flow first read drive", dOutEn, 1);
    chk("R9 flow first read data", dOut, model[40]);
    cmdWrite(8'd42, 4'h0);
    tick;
    chk("R9 flow write slot", dOutEn, 0);
    dIn = 32'h0F0F_1234;
    cmdRead(8'd42);
    tick;
    dIn = '0;
    cmdIdle;
    model[42] = 32'h0F0F_1234;
    chk("R9 flow second read drive", dOutEn, 1);
    chk("R9 flow second read data", dOut, model[42]);
    tick;
  endtask

  initial begin
    for (int w = 0; w < DEPTH; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_pipeBasic;
    t_byteMask;
    t_flow;
    t_deselect;
    t_suspend;
    t_backToBack;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule